// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block collects interrupt events from twelve sources of a small 8-bit processor: external pins, four timers, the analog converter, the watchdog, the interval timer and the serial port. Each event sets a sticky request flag. A flag becomes eligible when its per-source enable bit and a global master enable are both set. Among the eligible flags, the one of highest priority is chosen. The block then raises a request to the CPU and presents a 16-bit vector address for that source.

Software reaches four byte-wide registers through an address, write-data, read-data and write-strobe port. Two of these registers hold the enables and two hold the request flags. The CPU sets the master enable with a single-cycle pulse. When the CPU acknowledges a request, the master enable clears, so no other interrupt is taken until software enables it again. Hardware never clears the request flags. Software clears them by writing zero to the flag bit.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, all enable bits, all request flags and the master enable are 0, `irq_o` is 0, and every register reads 0.
- R2: Source index s has this priority order: 0 ext0, 1 ext1, 2 tmr0, 3 tmr1, 4 ext2, 5 ext3, 6 tmr2, 7 tmr3, 8 adc, 9 wdog, 10 ival, 11 serial. Enable bits for sources 0..7 sit at address E2h, bit 7-s. Enable bits for sources 8..11 sit at address E3h, bit 15-s. Request flags use the same bit positions at E4h (sources 0..7) and E5h (sources 8..11). Any other address reads 0.
- R3: A 1 on `src_evt_i[s]` at a clock edge sets flag s. The flag stays 1 until software writes 0 to it.
- R4: A write to a request register loads each implemented flag from the write data. If an event and a write to the same flag arrive in the same cycle, the flag ends at 1.
- R5: Source s is eligible only when its enable bit, its flag and the master enable are all 1. While no source is eligible and no request is held, `irq_o` stays 0. When a source becomes eligible, `irq_o` rises at the next clock edge.
- R6: The lowest eligible index wins. Its vector is FFFAh - 2*s, so source 0 gives FFFAh and source 11 gives FFE4h.
- R7: Once `irq_o` is 1, both `irq_o` and `vec_o` hold their values until `ack_i` is sampled high. `irq_o` is 0 after the edge that samples the acknowledge.
- R8: `mie_set_i` sets the master enable, which is visible on `mie_o`. An acknowledge while `irq_o` is 1 clears it, and the acknowledge wins over a set in the same cycle.
- R9: Bits 3..0 of E3h and E5h are not implemented. They read 0 and ignore writes.
- R10: An acknowledge leaves every request flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Register write data |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Register read data, combinational |
| src_evt_i | input | 12 | Event pulses, one per source, index = priority |
| mie_set_i | input | 1 | Sets the master enable |
| ack_i | input | 1 | CPU acknowledge of the current request |
| mie_o | output | 1 | Master enable state |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 16 | Vector address of the current request |

## Verification
The hardest situation to reach is a held request that competes with a new, higher-priority flag. The bench raises a request for a low-priority source and, while it waits unacknowledged, writes a flag of higher priority. It then checks that the vector does not move until the acknowledge. Only after software enables again does the vector change to the new source. A second hard case is an event and a software clear striking the same flag in the same cycle. The bench drives both on one clock edge and then reads the flag back.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 12;
  localparam int IDX_W   = $clog2(NUM_SRC);
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_regs.sv
module irq_regs import irq_pkg::*; #(
  parameter logic [7:0] A_EN_HI = 8'hE2,
  parameter logic [7:0] A_EN_LO = 8'hE3,
  parameter logic [7:0] A_RQ_HI = 8'hE4,
  parameter logic [7:0] A_RQ_LO = 8'hE5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       wr_i,
  input  src_vec_t   evt_i,
  output src_vec_t   en_o,
  output src_vec_t   flag_o,
  output logic [7:0] rdata_o
);
  src_vec_t en_q, flag_q;
  logic [7:0] en_hi, en_lo, rq_hi, rq_lo;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int BIT = 7 - (s % 8);
    localparam logic [7:0] EN_ADDR = (s < 8) ? A_EN_HI : A_EN_LO;
    localparam logic [7:0] RQ_ADDR = (s < 8) ? A_RQ_HI : A_RQ_LO;
    logic en_hit, rq_hit;
    assign en_hit = wr_i && (addr_i == EN_ADDR);
    assign rq_hit = wr_i && (addr_i == RQ_ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[s]   <= 1'b0;
        flag_q[s] <= 1'b0;
      end else begin
        if (en_hit) en_q[s] <= wdata_i[BIT];
        if (evt_i[s])    flag_q[s] <= 1'b1;  // event beats software write
        else if (rq_hit) flag_q[s] <= wdata_i[BIT];
      end
    end

    AST_EVT_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[s] |=> flag_q[s]);  // R4
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q[s] && !rq_hit |=> flag_q[s]);  // R10
  end

  always_comb begin
    en_hi = '0; en_lo = '0; rq_hi = '0; rq_lo = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (s < 8) begin
        en_hi[7-s] = en_q[s];
        rq_hi[7-s] = flag_q[s];
      end else begin
        en_lo[15-s] = en_q[s];
        rq_lo[15-s] = flag_q[s];
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_EN_HI: rdata_o = en_hi;
      A_EN_LO: rdata_o = en_lo;
      A_RQ_HI: rdata_o = rq_hi;
      A_RQ_LO: rdata_o = rq_lo;
      default: rdata_o = '0;
    endcase
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_EN_LO || addr_i == A_RQ_LO) |-> rdata_o[3:0] == 4'h0);  // R9

  assign en_o   = en_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio import irq_pkg::*; (
  input  src_vec_t         req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output src_vec_t         gnt_o
);
  always_comb begin
    idx_o = '0;
    gnt_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        gnt_o = src_vec_t'(1) << i;
      end
    end
    valid_o = |req_i;
  end

  always_comb begin
    AST_GNT_ONEHOT: assert ($onehot0(gnt_o) && ((gnt_o & ~req_i) == '0));  // R6
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl import irq_pkg::*; #(
  parameter logic [15:0] VEC_TOP = 16'hFFFA,
  parameter logic [7:0]  A_EN_HI = 8'hE2,
  parameter logic [7:0]  A_EN_LO = 8'hE3,
  parameter logic [7:0]  A_RQ_HI = 8'hE4,
  parameter logic [7:0]  A_RQ_LO = 8'hE5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [7:0]          addr_i,
  input  logic [7:0]          wdata_i,
  input  logic                wr_i,
  output logic [7:0]          rdata_o,
  input  logic [NUM_SRC-1:0]  src_evt_i,
  input  logic                mie_set_i,
  input  logic                ack_i,
  output logic                mie_o,
  output logic                irq_o,
  output logic [15:0]         vec_o
);
  src_vec_t en, flag, pend, gnt;
  logic             pend_vld;
  logic [IDX_W-1:0] pend_idx;
  logic             mie_q, irq_q;
  logic [15:0]      vec_q;
  logic             take;

  irq_regs #(
    .A_EN_HI(A_EN_HI), .A_EN_LO(A_EN_LO), .A_RQ_HI(A_RQ_HI), .A_RQ_LO(A_RQ_LO)
  ) i_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i,
    .evt_i(src_evt_i), .en_o(en), .flag_o(flag), .rdata_o
  );

  assign pend = en & flag & {NUM_SRC{mie_q}};

  irq_prio i_prio (.req_i(pend), .valid_o(pend_vld), .idx_o(pend_idx), .gnt_o(gnt));

  assign take = irq_q && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mie_q <= 1'b0;
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      if (take)           mie_q <= 1'b0;
      else if (mie_set_i) mie_q <= 1'b1;
      if (irq_q) begin
        if (ack_i) irq_q <= 1'b0;
      end else if (pend_vld) begin
        irq_q <= 1'b1;
        vec_q <= VEC_TOP - {{(15-IDX_W){1'b0}}, pend_idx, 1'b0};
      end
    end
  end

  AST_IRQ_NEEDS_MIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(mie_q));  // R5
  AST_VEC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !ack_i |=> irq_q && $stable(vec_q));  // R7
  AST_ACK_CLR_MIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && ack_i |=> !mie_q && !irq_q);  // R8

  assign mie_o = mie_q;
  assign irq_o = irq_q;
  assign vec_o = vec_q;
endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic        wr = 1'b0, mie_set = 1'b0, ack = 1'b0;
  logic [N-1:0] evt = '0;
  logic        mie, irq;
  logic [15:0] vec;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .rdata_o(rdata), .src_evt_i(evt), .mie_set_i(mie_set), .ack_i(ack),
    .mie_o(mie), .irq_o(irq), .vec_o(vec)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hi_byte(input logic [N-1:0] m);
    logic [7:0] b = '0;
    for (int s = 0; s < 8; s++) b[7-s] = m[s];
    return b;
  endfunction

  function automatic logic [7:0] lo_byte(input logic [N-1:0] m);
    logic [7:0] b = '0;
    for (int s = 8; s < N; s++) b[15-s] = m[s];
    return b;
  endfunction

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(req, {8'h00, rdata}, {8'h00, exp});
  endtask

  task automatic set_flags(input logic [N-1:0] m);
    wr_reg(8'hE4, hi_byte(m));
    wr_reg(8'hE5, lo_byte(m));
  endtask

  task automatic pulse_mie;
    mie_set = 1'b1;
    @(negedge clk);
    mie_set = 1'b0;
  endtask

  task automatic pulse_ack;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // set flags, enable, check the winner, acknowledge, clear
  task automatic take_one(input string req, input logic [N-1:0] m, input int win);
    set_flags(m);
    pulse_mie;
    @(negedge clk);
    chk({req, " irq"}, {15'h0, irq}, 16'h1);
    chk({req, " vec"}, vec, 16'hFFFA - 16'(2 * win));
    pulse_ack;
    chk("R8 ack clears mie", {15'h0, mie}, 16'h0);
    chk("R7 irq drops after ack", {15'h0, irq}, 16'h0);
    set_flags('0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 mie", {15'h0, mie}, 16'h0);
    rd_chk("R1 E2", 8'hE2, 8'h00);
    rd_chk("R1 E3", 8'hE3, 8'h00);
    rd_chk("R1 E4", 8'hE4, 8'h00);
    rd_chk("R1 E5", 8'hE5, 8'h00);

    // R2 / R9 register map
    wr_reg(8'hE2, 8'hA5);
    rd_chk("R2 E2 readback", 8'hE2, 8'hA5);
    wr_reg(8'hE3, 8'hFF);
    rd_chk("R9 E3 low nibble", 8'hE3, 8'hF0);
    wr_reg(8'hE5, 8'h0F);
    rd_chk("R9 E5 low nibble", 8'hE5, 8'h00);
    rd_chk("R2 other addr", 8'h10, 8'h00);
    rd_chk("R2 E4 untouched", 8'hE4, 8'h00);

    // R3 event sets sticky flag
    evt[3] = 1'b1;
    @(negedge clk);
    evt = '0;
    repeat (3) @(negedge clk);
    rd_chk("R3 tmr1 flag sticky", 8'hE4, 8'h10);
    wr_reg(8'hE4, 8'h00);
    rd_chk("R3 sw clear", 8'hE4, 8'h00);
    wr_reg(8'hE4, 8'h80);
    rd_chk("R4 sw set ext0", 8'hE4, 8'h80);
    wr_reg(8'hE4, 8'h00);

    // R4 event wins over clear in same cycle
    evt[9] = 1'b1;
    wr_reg(8'hE5, 8'h00);
    evt = '0;
    rd_chk("R4 event beats write", 8'hE5, 8'h40);
    wr_reg(8'hE5, 8'h00);

    // R5 eligibility
    wr_reg(8'hE2, 8'hFF);
    wr_reg(8'hE3, 8'hF0);
    evt[5] = 1'b1;
    @(negedge clk);
    evt = '0;
    repeat (3) @(negedge clk);
    chk("R5 no irq without mie", {15'h0, irq}, 16'h0);
    wr_reg(8'hE2, 8'hFB);
    pulse_mie;
    chk("R8 mie set", {15'h0, mie}, 16'h1);
    repeat (3) @(negedge clk);
    chk("R5 no irq when disabled", {15'h0, irq}, 16'h0);
    wr_reg(8'hE2, 8'hFF);
    chk("R5 not yet raised", {15'h0, irq}, 16'h0);
    @(negedge clk);
    chk("R5 irq raised", {15'h0, irq}, 16'h1);
    chk("R6 ext3 vector", vec, 16'hFFF0);
    pulse_ack;
    chk("R8 mie cleared", {15'h0, mie}, 16'h0);
    rd_chk("R10 flag kept after ack", 8'hE4, 8'h04);
    set_flags('0);

    // R6 single sources
    for (int i = 0; i < N; i++) take_one("R6 single", N'(1) << i, i);
    // R6 all pairs
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        take_one("R6 pair", (N'(1) << i) | (N'(1) << j), i);

    // R7 held vector against higher-priority arrival
    set_flags(N'(1) << 6);
    pulse_mie;
    @(negedge clk);
    chk("R7 tmr2 vec", vec, 16'hFFEE);
    set_flags((N'(1) << 6) | (N'(1) << 1));
    repeat (3) @(negedge clk);
    chk("R7 irq held", {15'h0, irq}, 16'h1);
    chk("R7 vec held", vec, 16'hFFEE);
    pulse_ack;
    pulse_mie;
    @(negedge clk);
    chk("R7 new vec after re-enable", vec, 16'hFFF8);
    // R8 ack wins over set
    ack = 1'b1; mie_set = 1'b1;
    @(negedge clk);
    ack = 1'b0; mie_set = 1'b0;
    chk("R8 ack beats set", {15'h0, mie}, 16'h0);
    set_flags('0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule